// File: doc/BRIEF.md
# CSR read-modify-write unit

This block holds a small set of control and status registers and carries out the six read-modify-write access kinds on them. The three kinds are replace, bit-set and bit-clear. Each kind comes in a form that takes a full 32-bit register operand and a form that takes a 5-bit unsigned immediate. Every access returns the register's previous contents on `rd_data` in the same cycle. Any update it causes takes effect at the next rising clock edge.

The register set has two parts. The first is one floating-point control/status store, made of a 3-bit rounding-mode field and a 5-bit accumulated-exception field. It is reachable through three addresses: the flags alone, the rounding mode alone, and both packed together. The second part is two free-running 64-bit counters. One counts clock cycles and the other counts retired instructions, and each is readable as a low word and a high word. The surrounding pipeline supplies the address, the access kind, the operand, a flag saying the register operand came from the hard-wired zero register, and a one-cycle pulse for each retired instruction.

Top module: `csr_rmw_unit`

## Requirements
- R1: `rd_data` always shows the addressed register's current value, zero-extended to 32 bits, combinationally. A modification made by an access becomes visible on the cycle after the access.
- R2: Replace kind (`csr_op` 3'b001 register, 3'b101 immediate) stores the operand. It writes even when `src_is_x0` is high.
- R3: Set kind (`csr_op` 3'b010 register, 3'b110 immediate) ORs the operand into the register.
- R4: Clear kind (`csr_op` 3'b011 register, 3'b111 immediate) ANDs the register with the inverted operand. `csr_op` 3'b000 and 3'b100 perform no access update.
- R5: Immediate forms (`csr_op[2]`=1) use `src_val[4:0]` zero-extended as the operand and ignore `src_val[31:5]`.
- R6: Set and clear make no write when `src_is_x0` is high in register form, or when `src_val[4:0]` is zero in immediate form. This holds whatever the other operand bits are.
- R7: Address 0x002 is the rounding-mode view: `rd_data[2:0]` is the mode, upper bits are zero, and a write keeps only bits [2:0] and leaves the flags untouched.
- R8: Address 0x001 is the flags view: `rd_data[4:0]` is the flags, upper bits are zero, and a write keeps only bits [4:0] and leaves the mode untouched.
- R9: Address 0x003 is the packed view {mode[2:0], flags[4:0]} in bits [7:0]. It shares storage with the other two views.
- R10: The cycle counter increments on every clock edge out of reset. Its low word is at 0xC00 and its high word at 0xC80.
- R11: The retired-instruction counter increments on each edge where `retire_pulse` is high. Its low word is at 0xC02 and its high word at 0xC82.
- R12: Counter addresses are read-only and writes to them are ignored. Any other address reads as zero and ignores writes.
- R13: A read in the same cycle as a counter increment returns the value before the increment.
- R14: While `rst_n` is low, all storage and both counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_addr | input | 12 | Register address |
| csr_op | input | 3 | Access kind; bit 2 selects immediate form |
| src_val | input | 32 | Register operand, or immediate in bits [4:0] |
| src_is_x0 | input | 1 | Register operand came from the zero register |
| retire_pulse | input | 1 | One instruction retired this cycle |
| rd_data | output | 32 | Previous value of the addressed register |

## Verification
Directed sequences first load the packed view with a known pattern. They then apply each access kind to each floating-point view, so that a mode write leaking into the flags (or the reverse) shows up on the next packed read. The immediate forms are driven with junk in `src_val[31:5]`, which separates correct truncation from use of the full operand. The set and clear forms are driven with a zero-register indication or zero immediate alongside nonzero other bits, which exposes a missing write suppression. Counter reads are interleaved with retire pulses and attempted writes to show pre-increment sampling and read-only behaviour, and a long random mix of addresses and kinds is compared against the reference model every clock.

// File: rtl/csr_rmw_pkg.sv
package csr_rmw_pkg;

  localparam int CSR_AW = 12;

  typedef enum logic [1:0] {
    KIND_NONE  = 2'b00,
    KIND_WRITE = 2'b01,
    KIND_SET   = 2'b10,
    KIND_CLEAR = 2'b11
  } rmw_kind_e;

  localparam logic [CSR_AW-1:0] ADR_FLAGS  = 12'h001;
  localparam logic [CSR_AW-1:0] ADR_RMODE  = 12'h002;
  localparam logic [CSR_AW-1:0] ADR_FPALL  = 12'h003;
  localparam logic [CSR_AW-1:0] ADR_CYC_LO = 12'hC00;
  localparam logic [CSR_AW-1:0] ADR_RET_LO = 12'hC02;
  localparam logic [CSR_AW-1:0] ADR_CYC_HI = 12'hC80;
  localparam logic [CSR_AW-1:0] ADR_RET_HI = 12'hC82;

endpackage

// File: rtl/csr_rmw_alu.sv
module csr_rmw_alu
  import csr_rmw_pkg::*;
#(
  parameter int W      = 32,
  parameter int UIMM_W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   op,
  input  logic [W-1:0] src_val,
  input  logic         src_is_x0,
  input  logic [W-1:0] old_val,
  output logic [W-1:0] new_val,
  output logic         wr_en
);

  rmw_kind_e    kind;
  logic         use_imm;
  logic [W-1:0] operand;
  logic         quiet;

  assign kind    = rmw_kind_e'(op[1:0]);
  assign use_imm = op[2];

  always_comb begin
    if (use_imm) begin
      operand = {{(W-UIMM_W){1'b0}}, src_val[UIMM_W-1:0]};
      quiet   = (src_val[UIMM_W-1:0] == '0);
    end else begin
      operand = src_val;
      quiet   = src_is_x0;
    end
  end

  always_comb begin
    new_val = old_val;
    wr_en   = 1'b0;
    case (kind)
      KIND_WRITE: begin
        new_val = operand;
        wr_en   = 1'b1;
      end
      KIND_SET: begin
        new_val = old_val | operand;
        wr_en   = !quiet;
      end
      KIND_CLEAR: begin
        new_val = old_val & ~operand;
        wr_en   = !quiet;
      end
      default: begin
        new_val = old_val;
        wr_en   = 1'b0;
      end
    endcase
  end

  // R3
  set_keeps_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op[1:0] == 2'b10 && wr_en) |-> ((new_val & old_val) == old_val));

  // R4
  clear_drops_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op[1:0] == 2'b11 && wr_en) |-> ((new_val & ~old_val) == '0));

  // R6
  zero_imm_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op[2] && op[1] && src_val[UIMM_W-1:0] == '0) |-> !wr_en);

  // R6
  x0_reg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!op[2] && op[1] && src_is_x0) |-> !wr_en);

endmodule

// File: rtl/csr_fp_status.sv
module csr_fp_status #(
  parameter int FRM_W = 3,
  parameter int FLG_W = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_flags,
  input  logic                   wr_rmode,
  input  logic                   wr_full,
  input  logic [FRM_W+FLG_W-1:0] wdata,
  output logic [FRM_W-1:0]       frm,
  output logic [FLG_W-1:0]       fflags
);

  logic [FRM_W-1:0] frm_q, frm_d;
  logic [FLG_W-1:0] flg_q, flg_d;
  logic             upd_en;

  assign upd_en = wr_flags | wr_rmode | wr_full;

  always_comb begin
    frm_d = frm_q;
    flg_d = flg_q;
    if (wr_flags) flg_d = wdata[FLG_W-1:0];
    if (wr_rmode) frm_d = wdata[FRM_W-1:0];
    if (wr_full) begin
      frm_d = wdata[FRM_W+FLG_W-1:FLG_W];
      flg_d = wdata[FLG_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frm_q <= '0;
      flg_q <= '0;
    end else if (upd_en) begin
      frm_q <= frm_d;
      flg_q <= flg_d;
    end
  end

  assign frm    = frm_q;
  assign fflags = flg_q;

  // R1
  fp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_en |=> $stable({frm, fflags}));

  // R7
  rmode_spares_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_rmode && !wr_flags && !wr_full) |=> $stable(fflags));

  // R8
  flags_spares_rmode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_flags && !wr_rmode && !wr_full) |=> $stable(frm));

endmodule

// File: rtl/csr_wide_counter.sv
module csr_wide_counter #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] value
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (inc) begin
      cnt_q <= cnt_d;
    end
  end

  assign value = cnt_q;

  // R10
  step_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inc |=> (value == $past(value) + 1'b1));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inc |=> $stable(value));

endmodule

// File: rtl/csr_rmw_unit.sv
module csr_rmw_unit
  import csr_rmw_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int UIMM_W = 5,
  parameter int FRM_W  = 3,
  parameter int FLG_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CSR_AW-1:0] csr_addr,
  input  logic [2:0]        csr_op,
  input  logic [XLEN-1:0]   src_val,
  input  logic              src_is_x0,
  input  logic              retire_pulse,
  output logic [XLEN-1:0]   rd_data
);

  localparam int CNT_W = 2 * XLEN;
  localparam int FP_W  = FRM_W + FLG_W;
  localparam int N_CNT = 2;

  logic [N_CNT-1:0] cnt_inc;
  logic [CNT_W-1:0] cnt_val [N_CNT];
  logic [FRM_W-1:0] frm;
  logic [FLG_W-1:0] fflags;
  logic [XLEN-1:0]  new_val;
  logic             alu_we;
  logic             wr_flags, wr_rmode, wr_full;
  logic             unused_upper;

  // index 0: clock cycles, index 1: retired instructions
  assign cnt_inc = {retire_pulse, 1'b1};

  for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
    csr_wide_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (cnt_inc[g]),
      .value (cnt_val[g])
    );
  end

  always_comb begin
    rd_data = '0;
    case (csr_addr)
      ADR_FLAGS:  rd_data[FLG_W-1:0] = fflags;
      ADR_RMODE:  rd_data[FRM_W-1:0] = frm;
      ADR_FPALL:  rd_data[FP_W-1:0]  = {frm, fflags};
      ADR_CYC_LO: rd_data = cnt_val[0][XLEN-1:0];
      ADR_CYC_HI: rd_data = cnt_val[0][CNT_W-1:XLEN];
      ADR_RET_LO: rd_data = cnt_val[1][XLEN-1:0];
      ADR_RET_HI: rd_data = cnt_val[1][CNT_W-1:XLEN];
      default:    rd_data = '0;
    endcase
  end

  csr_rmw_alu #(.W(XLEN), .UIMM_W(UIMM_W)) u_alu (
    .clk       (clk),
    .rst_n     (rst_n),
    .op        (csr_op),
    .src_val   (src_val),
    .src_is_x0 (src_is_x0),
    .old_val   (rd_data),
    .new_val   (new_val),
    .wr_en     (alu_we)
  );

  assign wr_flags     = alu_we && (csr_addr == ADR_FLAGS);
  assign wr_rmode     = alu_we && (csr_addr == ADR_RMODE);
  assign wr_full      = alu_we && (csr_addr == ADR_FPALL);
  assign unused_upper = |new_val[XLEN-1:FP_W];

  csr_fp_status #(.FRM_W(FRM_W), .FLG_W(FLG_W)) u_fp (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_flags (wr_flags),
    .wr_rmode (wr_rmode),
    .wr_full  (wr_full),
    .wdata    (new_val[FP_W-1:0]),
    .frm      (frm),
    .fflags   (fflags)
  );

  // R12
  counter_readonly_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((csr_addr == ADR_RET_LO || csr_addr == ADR_RET_HI) && !retire_pulse)
      |=> $stable(cnt_val[1]));

  // R12
  unmapped_no_fp_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_addr != ADR_FLAGS && csr_addr != ADR_RMODE && csr_addr != ADR_FPALL)
      |=> $stable({frm, fflags}));

endmodule

// File: tb/sim_csr_rmw_unit.sv
module sim_csr_rmw_unit;
  import csr_rmw_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] csr_addr = '0;
  logic [2:0]  csr_op = '0;
  logic [31:0] src_val = '0;
  logic        src_is_x0 = 1'b0;
  logic        retire_pulse = 1'b0;
  logic [31:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [2:0]  m_frm = '0;
  logic [4:0]  m_flg = '0;
  longint unsigned m_cyc = 0;
  longint unsigned m_ret = 0;

  always #10 clk = ~clk;

  csr_rmw_unit u0 (
    .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_op(csr_op),
    .src_val(src_val), .src_is_x0(src_is_x0), .retire_pulse(retire_pulse),
    .rd_data(rd_data)
  );

  function automatic logic [31:0] m_read(input logic [11:0] a);
    case (a)
      ADR_FLAGS:  return {27'd0, m_flg};
      ADR_RMODE:  return {29'd0, m_frm};
      ADR_FPALL:  return {24'd0, m_frm, m_flg};
      ADR_CYC_LO: return m_cyc[31:0];
      ADR_CYC_HI: return m_cyc[63:32];
      ADR_RET_LO: return m_ret[31:0];
      ADR_RET_HI: return m_ret[63:32];
      default:    return 32'd0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s addr=%h op=%0d actual=%h expected=%h", tag, csr_addr, csr_op, act, exp);
    end
  endtask

  // One clock: drive after negedge, compare, update model at posedge.
  task automatic step(input logic [11:0] a, input logic [2:0] op, input logic [31:0] s,
                      input logic x0, input logic rp, input string tag);
    logic [31:0] ex, opnd, nv;
    logic quiet, we;
    csr_addr = a; csr_op = op; src_val = s; src_is_x0 = x0; retire_pulse = rp;
    #2;
    ex = m_read(a);
    check(tag, rd_data, ex);
    @(posedge clk);
    opnd  = op[2] ? {27'd0, s[4:0]} : s;
    quiet = op[2] ? (s[4:0] == 5'd0) : x0;
    nv = ex; we = 1'b0;
    case (op[1:0])
      2'b01: begin nv = opnd; we = 1'b1; end
      2'b10: begin nv = ex | opnd; we = !quiet; end
      2'b11: begin nv = ex & ~opnd; we = !quiet; end
      default: we = 1'b0;
    endcase
    if (we) begin
      if (a == ADR_FLAGS) m_flg = nv[4:0];
      else if (a == ADR_RMODE) m_frm = nv[2:0];
      else if (a == ADR_FPALL) begin m_frm = nv[7:5]; m_flg = nv[4:0]; end
    end
    m_cyc++;
    if (rp) m_ret++;
    @(negedge clk);
  endtask

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [11:0] alist [8];
    alist = '{ADR_FLAGS, ADR_RMODE, ADR_FPALL, ADR_CYC_LO, ADR_CYC_HI,
              ADR_RET_LO, ADR_RET_HI, 12'h345};
    // R14: reset state on every view
    repeat (3) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      csr_addr = alist[i];
      #2;
      check("R14", rd_data, 32'd0);
      @(negedge clk);
    end
    rst_n = 1'b1;
    step(ADR_CYC_LO, 3'b000, 0, 0, 0, "R14");
    // R2 replace with junk upper bits, then views (R1 old value returned)
    step(ADR_FPALL, 3'b001, 32'hFFFF_FFA5, 0, 0, "R2");
    step(ADR_FPALL, 3'b000, 0, 0, 0, "R1");
    step(ADR_FLAGS, 3'b000, 0, 0, 0, "R8");
    step(ADR_RMODE, 3'b000, 0, 0, 0, "R7");
    // R3 set, R4 clear
    step(ADR_FLAGS, 3'b010, 32'h0000_001A, 0, 0, "R3");
    step(ADR_FPALL, 3'b000, 0, 0, 0, "R3");
    step(ADR_RMODE, 3'b011, 32'hFFFF_FFF5, 0, 0, "R4");
    step(ADR_FPALL, 3'b000, 0, 0, 0, "R4");
    // R5 immediate forms ignore upper source bits
    step(ADR_FPALL, 3'b101, 32'hFFFF_FFE3, 0, 0, "R5");
    step(ADR_RMODE, 3'b110, 32'hABCD_EF04, 0, 0, "R5");
    step(ADR_FLAGS, 3'b111, 32'h1234_561F, 0, 0, "R5");
    step(ADR_FPALL, 3'b000, 0, 0, 0, "R5");
    // R6 suppressed writes
    step(ADR_FPALL, 3'b010, 32'h0000_00FF, 1, 0, "R6");
    step(ADR_FPALL, 3'b110, 32'hFFFF_FFE0, 0, 0, "R6");
    step(ADR_FPALL, 3'b011, 32'hFFFF_FFFF, 1, 0, "R6");
    step(ADR_FPALL, 3'b111, 32'h0000_0F00, 0, 0, "R6");
    step(ADR_FPALL, 3'b000, 0, 0, 0, "R6");
    // R2 replace still writes with zero-register flag
    step(ADR_FPALL, 3'b001, 32'h0000_003C, 1, 0, "R2");
    step(ADR_FPALL, 3'b000, 0, 0, 0, "R2");
    // R7, R8 view truncation and isolation; R9 packed view
    step(ADR_RMODE, 3'b001, 32'hFFFF_FFFE, 0, 0, "R7");
    step(ADR_FPALL, 3'b000, 0, 0, 0, "R7");
    step(ADR_FLAGS, 3'b001, 32'hFFFF_FFF3, 0, 0, "R8");
    step(ADR_FPALL, 3'b000, 0, 0, 0, "R9");
    step(ADR_FPALL, 3'b001, 32'h0000_0000, 0, 0, "R9");
    step(ADR_RMODE, 3'b000, 0, 0, 0, "R9");
    // R10 cycle counter
    for (int i = 0; i < 4; i++) step(ADR_CYC_LO, 3'b000, 0, 0, 0, "R10");
    step(ADR_CYC_HI, 3'b000, 0, 0, 0, "R10");
    // R11 retire counter, R13 same-cycle read sees pre-increment
    for (int i = 0; i < 5; i++) step(ADR_RET_LO, 3'b000, 0, 0, (i % 2) == 0, "R11");
    step(ADR_RET_LO, 3'b000, 0, 0, 1, "R13");
    step(ADR_RET_LO, 3'b000, 0, 0, 1, "R13");
    step(ADR_CYC_LO, 3'b000, 0, 0, 1, "R13");
    step(ADR_RET_HI, 3'b000, 0, 0, 0, "R11");
    // R12 read-only and unmapped
    step(ADR_CYC_LO, 3'b001, 32'h0000_0000, 0, 0, "R12");
    step(ADR_CYC_LO, 3'b000, 0, 0, 0, "R12");
    step(ADR_RET_HI, 3'b001, 32'hFFFF_FFFF, 0, 0, "R12");
    step(ADR_RET_LO, 3'b111, 32'h0000_001F, 0, 0, "R12");
    step(ADR_RET_HI, 3'b000, 0, 0, 0, "R12");
    step(ADR_RET_LO, 3'b000, 0, 0, 0, "R12");
    step(12'h7FF, 3'b010, 32'hFFFF_FFFF, 0, 0, "R12");
    step(12'h7FF, 3'b000, 0, 0, 0, "R12");
    step(ADR_FPALL, 3'b000, 0, 0, 0, "R12");
    // R1 random mix against the model
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(alist[r[2:0]], r[5:3], $urandom, r[6], r[7], "R1");
    end
    summary();
  end

endmodule